// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a 12-bit charge-balancing successive-approximation converter. It runs a fixed frame of 15 clock periods: three periods in which the capacitor array follows the input and the comparator auto-zeroes, then twelve periods in which one bit per period is tried and decided, from the most significant bit down. The last decision and all earlier ones are moved together into an output register at the end of the frame, and a data-ready flag marks the new word.

Conversions run back to back while the active-low start request stays low. If start is high when period 1 ends, the sequencer parks in period 2: the array keeps following the input, data-ready stays high and the result is held. A low start then resumes the frame at period 3. The analog array and comparator are outside the block. They appear only as the per-bit reference-select vector (bit i = 1 connects the weight-2^i element to the positive reference) and a single comparator bit (1 = input at or above the level the array currently presents).

The controller has three states. TRACK covers periods 1 to 3. PARK is period 2 held. TRIAL covers periods 4 to 15. The transitions are:
- ACCEPT: TRACK period 1 to period 2, when start is low.
- HALT: TRACK period 1 to PARK, when start is high.
- RESUME: PARK to TRACK period 3, when start is low.
- SETTLE: TRACK period 3 to TRIAL period 4.
- STEP: within TRIAL, from one period to the next.
- WRAP: TRIAL period 15 to TRACK period 1.

Top module: `sar_seq`

## Requirements
- R1: With start held low, a new result appears every 15 clock cycles, and data-ready is high in exactly one cycle of each 15.
- R2: In every tracking period (periods 1 to 3, and while parked), track and auto-zero are both 1 and the reference-select vector is all zero.
- R3: In period 4, track and auto-zero are 0 and the select vector has only bit 11 set.
- R4: Bits 11 down to 0 are tried one per period, in periods 4 to 15. A tried bit stays 1 in the select vector when the comparator bit is 1 at the end of its period, and returns to 0 otherwise. With an ideal comparator, the result equals the input code.
- R5: The result register (bit i has weight 2^i) loads all twelve decisions at the edge that ends period 15. From the next cycle the array is back in tracking.
- R6: The result register does not change at any time other than the cycle in which data-ready rises.
- R7: Data-ready rises at the start of period 1 after a conversion. It falls at the next edge when start is low at the end of period 1.
- R8: Start is sampled only at the end of period 1 and while parked. A high start during periods 2 to 15 has no effect on the frame.
- R9: A high start at the end of period 1 parks the sequence. While parked, data-ready stays at its value, track and auto-zero stay 1, the select vector stays zero and the result is unchanged.
- R10: A low start while parked clears data-ready at the next edge and continues with period 3. The new result appears 13 cycles after the accepting edge.
- R11: Synchronous reset puts the sequence in period 1 of TRACK, with data-ready 0, result 0 and select vector 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every step happens on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_n | input | 1 | Conversion request, active low |
| cmp_hi | input | 1 | Comparator decision, 1 when the input is at or above the array level |
| ref_sel | output | NBITS | Per-element reference select, 1 = positive reference |
| track_en | output | 1 | Array connected to the input |
| azero_en | output | 1 | Comparator auto-zero enable |
| result | output | NBITS | Latched conversion result |
| drdy | output | 1 | Data-ready flag |

## Verification
The bound checker checks on every cycle that tracking always comes with auto-zero and a cleared select vector, and that the first trial period presents only the MSB. It also checks that the result moves only when data-ready rises, that data-ready rises only on the way out of a trial period, that a parked sequence holds everything, and that an accepted start clears data-ready. Only the bench scenarios can show that the decisions produce the right code: an ideal comparator is swept over all 4096 input codes. The bench scenarios also cover the exact 15- and 13-cycle latencies, and show that start glitches in the middle of a frame are ignored.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
    typedef enum logic [1:0] {
        ST_TRACK = 2'd0,
        ST_PARK  = 2'd1,
        ST_TRIAL = 2'd2
    } seq_state_e;
endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int NBITS  = 12,
    parameter int NTRACK = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_n,
    output logic [NBITS-1:0] try_bit,
    output logic             last_trial,
    output logic             track_en,
    output logic             azero_en,
    output logic             drdy
);
    localparam int NPER = NTRACK + NBITS;
    localparam int PW   = $clog2(NPER + 1);
    localparam logic [PW-1:0] P_FIRST = PW'(1);
    localparam logic [PW-1:0] P_PARK  = PW'(2);
    localparam logic [PW-1:0] P_AFTER = PW'(3);
    localparam logic [PW-1:0] P_SETTL = PW'(NTRACK);
    localparam logic [PW-1:0] P_LAST  = PW'(NPER);

    seq_state_e    st_q, st_d;
    logic [PW-1:0] per_q, per_d;
    logic          drdy_q, drdy_d;

    // next-state and transition logic
    always_comb begin
        st_d   = st_q;
        per_d  = per_q;
        drdy_d = drdy_q;
        unique case (st_q)
            ST_TRACK: begin
                if (per_q == P_FIRST) begin
                    per_d = P_PARK;
                    if (!start_n) begin
                        drdy_d = 1'b0;        // ACCEPT
                    end else begin
                        st_d = ST_PARK;       // HALT
                    end
                end else if (per_q == P_SETTL) begin
                    st_d  = ST_TRIAL;         // SETTLE
                    per_d = per_q + P_FIRST;
                end else begin
                    per_d = per_q + P_FIRST;
                end
            end
            ST_PARK: begin
                if (!start_n) begin
                    st_d   = ST_TRACK;        // RESUME
                    per_d  = P_AFTER;
                    drdy_d = 1'b0;
                end
            end
            ST_TRIAL: begin
                if (per_q == P_LAST) begin
                    st_d   = ST_TRACK;        // WRAP
                    per_d  = P_FIRST;
                    drdy_d = 1'b1;
                end else begin
                    per_d = per_q + P_FIRST;  // STEP
                end
            end
            default: begin
                st_d   = ST_TRACK;
                per_d  = P_FIRST;
                drdy_d = 1'b0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_TRACK;
            per_q  <= P_FIRST;
            drdy_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            per_q  <= per_d;
            drdy_q <= drdy_d;
        end
    end

    // bit under trial: bit i is tried in period NPER - i
    for (genvar i = 0; i < NBITS; i++) begin : g_try
        assign try_bit[i] = (st_q == ST_TRIAL) && (per_q == PW'(NPER - i));
    end

    // outputs
    always_comb begin
        track_en   = (st_q != ST_TRIAL);
        azero_en   = (st_q != ST_TRIAL);
        last_trial = try_bit[0];
        drdy       = drdy_q;
    end
endmodule

// File: rtl/sar_seq_trial.sv
module sar_seq_trial #(
    parameter int NBITS = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_hi,
    input  logic [NBITS-1:0] try_bit,
    input  logic             last_trial,
    output logic [NBITS-1:0] ref_sel,
    output logic [NBITS-1:0] result
);
    logic [NBITS-1:0] kept_q;

    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                kept_q[i] <= 1'b0;
            end else if (last_trial) begin
                kept_q[i] <= 1'b0;
            end else if (try_bit[i]) begin
                kept_q[i] <= cmp_hi;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                result[i] <= 1'b0;
            end else if (last_trial) begin
                result[i] <= try_bit[i] ? cmp_hi : kept_q[i];
            end
        end

        assign ref_sel[i] = kept_q[i] | try_bit[i];
    end
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
    parameter int NBITS  = 12,
    parameter int NTRACK = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_n,
    input  logic             cmp_hi,
    output logic [NBITS-1:0] ref_sel,
    output logic             track_en,
    output logic             azero_en,
    output logic [NBITS-1:0] result,
    output logic             drdy
);
    logic [NBITS-1:0] try_bit;
    logic             last_trial;

    sar_seq_ctrl #(.NBITS(NBITS), .NTRACK(NTRACK)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_n    (start_n),
        .try_bit    (try_bit),
        .last_trial (last_trial),
        .track_en   (track_en),
        .azero_en   (azero_en),
        .drdy       (drdy)
    );

    sar_seq_trial #(.NBITS(NBITS)) u_trial (
        .clk        (clk),
        .rst        (rst),
        .cmp_hi     (cmp_hi),
        .try_bit    (try_bit),
        .last_trial (last_trial),
        .ref_sel    (ref_sel),
        .result     (result)
    );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int NBITS = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             start_n,
    input logic [NBITS-1:0] ref_sel,
    input logic             track_en,
    input logic             azero_en,
    input logic [NBITS-1:0] result,
    input logic             drdy
);
    localparam logic [NBITS-1:0] MSB_ONLY = NBITS'(1) << (NBITS - 1);

    AST_TRACK_IDLE: assert property (@(posedge clk) disable iff (rst)
        track_en |-> (azero_en && ref_sel == '0)); // R2

    AST_MSB_FIRST: assert property (@(posedge clk) disable iff (rst)
        $fell(track_en) |-> (ref_sel == MSB_ONLY && !azero_en)); // R3

    AST_RISE_FROM_TRIAL: assert property (@(posedge clk) disable iff (rst)
        $rose(drdy) |-> (track_en && !$past(track_en))); // R5

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$rose(drdy) |-> $stable(result)); // R6

    AST_PARK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (drdy && $past(drdy)) |-> (track_en && $stable(result))); // R9

    AST_DRDY_DROP: assert property (@(posedge clk) disable iff (rst)
        ($past(drdy) && !$past(start_n) && $past(track_en)) |-> !drdy); // R10
endmodule

bind sar_seq sar_seq_chk #(.NBITS(NBITS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_n  (start_n),
    .ref_sel  (ref_sel),
    .track_en (track_en),
    .azero_en (azero_en),
    .result   (result),
    .drdy     (drdy)
);

// File: tb/sar_seq_test.sv
module sar_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_n = 1'b0;
    logic        cmp_hi;
    logic [11:0] ref_sel;
    logic        track_en;
    logic        azero_en;
    logic [11:0] result;
    logic        drdy;

    logic [11:0] code = 12'd0;
    logic [11:0] last_code = 12'd0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // ideal comparator
    assign cmp_hi = (code >= ref_sel);

    sar_seq uut (
        .clk(clk), .rst(rst), .start_n(start_n), .cmp_hi(cmp_hi),
        .ref_sel(ref_sel), .track_en(track_en), .azero_en(azero_en),
        .result(result), .drdy(drdy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Continuous conversion; entered at the negedge in period 1.
    task automatic run_free(input logic [11:0] c, input bit glitch);
        start_n = 1'b0;
        code = c;
        for (int k = 1; k <= 15; k++) begin
            @(negedge clk);
            if (k < 15) begin
                chk(drdy == 1'b0, "R7 drdy low inside frame", drdy, 0);
                chk(result == last_code, "R6 result held", result, last_code);
            end
            if (k == 1 || k == 2)
                chk(track_en && azero_en && ref_sel == 12'h0, "R2 tracking",
                    {track_en, azero_en, ref_sel}, {2'b11, 12'h0});
            if (k == 3)
                chk(!track_en && !azero_en && ref_sel == 12'h800, "R3 msb trial",
                    {track_en, azero_en, ref_sel}, {2'b00, 12'h800});
            if (k == 15) begin
                chk(drdy == 1'b1, "R1 drdy after 15 cycles", drdy, 1);
                chk(result == c, "R4 converted code", result, c);
                chk(track_en && ref_sel == 12'h0, "R5 back to track",
                    {track_en, ref_sel}, {1'b1, 12'h0});
            end
            if (glitch) start_n = (k >= 2 && k <= 13); // R8 ignored mid-frame
        end
        last_code = c;
    endtask

    // Single shot: park, then one start pulse; entered at the negedge in period 1.
    task automatic run_shot(input logic [11:0] c);
        start_n = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk(drdy && track_en && azero_en && ref_sel == 12'h0 && result == last_code,
                "R9 parked", {drdy, track_en, azero_en, ref_sel, result},
                {3'b111, 12'h0, last_code});
        end
        code = c;
        start_n = 1'b0;
        for (int k = 1; k <= 14; k++) begin
            @(negedge clk);
            if (k == 1) start_n = 1'b1;
            if (k < 14) chk(drdy == 1'b0, "R10 drdy cleared", drdy, 0);
            if (k == 1) chk(track_en == 1'b1, "R10 resumes in period 3", track_en, 1);
            if (k == 2) chk(ref_sel == 12'h800, "R10 trial after resume", ref_sel, 12'h800);
            if (k == 14) begin
                chk(drdy == 1'b1, "R10 drdy 13 cycles after accept", drdy, 1);
                chk(result == c, "R10 shot result", result, c);
            end
        end
        last_code = c;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(drdy == 1'b0 && result == 12'h0, "R11 reset outputs", {drdy, result}, 0);
        chk(track_en && azero_en && ref_sel == 12'h0, "R11 reset in track",
            {track_en, azero_en, ref_sel}, {2'b11, 12'h0});
        rst = 1'b0;
        for (int i = 0; i < 4096; i++) run_free(12'(i), (i % 97) == 5);
        run_shot(12'h000);
        run_shot(12'hFFF);
        run_shot(12'h555);
        run_shot(12'hAAA);
        run_free(12'h123, 1'b0);
        run_free(12'h000, 1'b1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule